// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small processor with a single accumulator. It sequences each instruction through a fetch phase and an execute phase against an external synchronous memory. The memory holds 16-bit words and is addressed by 12 bits. An address register stages every memory access. A data buffer register holds every word read back and every word about to be written. An instruction register keeps the current instruction word for the whole execute phase.

Each instruction word splits into an operation code and an operand address. Three operations are decoded: load the accumulator from memory, add a memory word into the accumulator, and write the accumulator to memory. Any other operation code stops the core, and it stays stopped until reset. A system uses the block by filling memory with a program that starts at word 0x300 and then releasing reset. It waits for the halt output and then reads the results out of memory.

Top module: `acc_core`

## Requirements
- R1: While reset is held, and after it is released, `halted` and `memWe` are low. The program counter starts at 0x300, so the first address driven on `memAddr` (one clock after release) is 0x300.
- R2: An instruction word carries its operation code in bits [15:12] and its operand address in bits [11:0]. All 4096 addresses, including 0xFFF, are reachable.
- R3: Operation code 0x1 replaces the accumulator with the memory word at the operand address. It does not add to the old value.
- R4: Operation code 0x2 writes the accumulator to the operand address with exactly one write strobe. `memWdata` equals the accumulator and `memAddr` equals the operand address.
- R5: Operation code 0x5 adds the addressed word to the accumulator modulo 2^16. No carry is kept.
- R6: Instructions execute from consecutive addresses. The program counter advances by one per fetch and changes in no other way.
- R7: Any operation code other than 0x1, 0x2 or 0x5 raises `halted`, which then stays high. After that no write is issued, `memAddr` stays frozen, and the halting word's address field has no effect.
- R8: The memory has one clock of read latency. A fetch takes four clocks, a load or add execute takes four more, and a store execute takes two. The store that ends a load, add, store sequence therefore raises `memWe` in the 21st clock after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 12 | Memory word address, driven from the address register |
| memWdata | output | 16 | Write data, driven from the data buffer register |
| memWe | output | 1 | Write enable for one clock per store |
| memRdata | input | 16 | Read data, valid the clock after the address is presented |
| halted | output | 1 | High once an undecoded operation code has been executed |

## Verification
The first program is a load, add, store sequence over two ordinary operands. It separates a correct sum from a plain copy and also fixes the exact clock of the write strobe. Operands of 0xFFFF and 0x0003 show whether the addition wraps or leaks a carry. A load followed by a second load before a store shows whether a load replaces the accumulator or accumulates into it. A longer chain of adds at the top of the address range shows whether instructions are fetched strictly in sequence and whether all twelve address bits decode. A halting word with a nonzero address field, followed by many idle clocks, shows whether the core really stops fetching and writing.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;

  typedef struct packed {
    logic marFromPc;
    logic marFromIr;
    logic mbrFromMem;
    logic mbrFromAcc;
    logic pcInc;
    logic irLoad;
    logic accLoad;
    logic accAdd;
    logic memWe;
  } ctrlStrobe_t;
endpackage

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RESET_PC = 12'h300
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strb,
  input  logic [OPC_W+ADDR_W-1:0] memRdata,
  output logic [OPC_W-1:0]       opcode,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [OPC_W+ADDR_W-1:0] memWdata
);
  localparam int WORD_W = OPC_W + ADDR_W;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] marReg;
  logic [WORD_W-1:0] mbrReg;
  logic [WORD_W-1:0] irReg;
  logic [WORD_W-1:0] accReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg  <= RESET_PC;
      marReg <= '0;
      mbrReg <= '0;
      irReg  <= '0;
      accReg <= '0;
    end else begin
      if (strb.marFromPc)      marReg <= pcReg;
      else if (strb.marFromIr) marReg <= irReg[ADDR_W-1:0];

      if (strb.mbrFromMem)      mbrReg <= memRdata;
      else if (strb.mbrFromAcc) mbrReg <= accReg;

      if (strb.pcInc)  pcReg <= pcReg + ADDR_W'(1);
      if (strb.irLoad) irReg <= mbrReg;

      if (strb.accLoad)     accReg <= mbrReg;
      else if (strb.accAdd) accReg <= accReg + mbrReg;
    end
  end

  assign opcode   = irReg[WORD_W-1:ADDR_W];
  assign memAddr  = marReg;
  assign memWdata = mbrReg;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pcReg != $past(pcReg)) |-> (pcReg == $past(pcReg) + ADDR_W'(1))); // R6
  AST_WE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWe |-> (memWdata == accReg)); // R4
  AST_WE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWe |-> (memAddr == irReg[ADDR_W-1:0])); // R4
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  output ctrlStrobe_t      strb,
  output logic             halted
);
  typedef enum logic [3:0] {
    ST_FADDR, ST_FWAIT, ST_FCAPT, ST_FIR,
    ST_EXEC, ST_OWAIT, ST_OCAPT, ST_OAPPLY,
    ST_STORE, ST_HALT
  } state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_FADDR;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      ST_FADDR: begin
        strb.marFromPc = 1'b1;
        stateD = ST_FWAIT;
      end
      ST_FWAIT: stateD = ST_FCAPT;
      ST_FCAPT: begin
        strb.mbrFromMem = 1'b1;
        strb.pcInc      = 1'b1;
        stateD = ST_FIR;
      end
      ST_FIR: begin
        strb.irLoad = 1'b1;
        stateD = ST_EXEC;
      end
      ST_EXEC: begin
        case (opcode)
          OPC_LOAD, OPC_ADD: begin
            strb.marFromIr = 1'b1;
            stateD = ST_OWAIT;
          end
          OPC_STORE: begin
            strb.marFromIr  = 1'b1;
            strb.mbrFromAcc = 1'b1;
            stateD = ST_STORE;
          end
          default: stateD = ST_HALT;
        endcase
      end
      ST_OWAIT: stateD = ST_OCAPT;
      ST_OCAPT: begin
        strb.mbrFromMem = 1'b1;
        stateD = ST_OAPPLY;
      end
      ST_OAPPLY: begin
        if (opcode == OPC_ADD) strb.accAdd  = 1'b1;
        else                   strb.accLoad = 1'b1;
        stateD = ST_FADDR;
      end
      ST_STORE: begin
        strb.memWe = 1'b1;
        stateD = ST_FADDR;
      end
      ST_HALT: stateD = ST_HALT;
      default: stateD = ST_HALT;
    endcase
  end

  assign halted = (stateQ == ST_HALT);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted); // R7
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !strb.memWe); // R7
  AST_HALT_NO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !(strb.marFromPc || strb.marFromIr)); // R7
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RESET_PC = 12'h300
) (
  input  logic                    clk,
  input  logic                    rstN,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [OPC_W+ADDR_W-1:0] memWdata,
  output logic                    memWe,
  input  logic [OPC_W+ADDR_W-1:0] memRdata,
  output logic                    halted
);
  ctrlStrobe_t      strb;
  logic [OPC_W-1:0] opcode;

  acc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .strb   (strb),
    .halted (halted)
  );

  acc_datapath #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .memRdata (memRdata),
    .opcode   (opcode),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  assign memWe = strb.memWe;
endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic        memWe;
  logic [15:0] memRdata;
  logic        halted;

  logic [15:0] mem [0:4095];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int firstWe;
  int weCount;

  always #5 clk = ~clk;

  acc_core u_dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
    if (rstN) cyc <= cyc + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enterReset();
    rstN = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0BAD;
    cyc = 0;
  endtask

  task automatic runProgram();
    firstWe = -1;
    weCount = 0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 400 && !halted; i++) begin
      @(negedge clk);
      if (cyc == 1) check("R1 first fetch addr", {20'd0, memAddr}, 32'h300);
      if (memWe) begin
        weCount++;
        if (firstWe < 0) firstWe = cyc;
      end
    end
    check("R7 halt reached", {31'd0, halted}, 32'd1);
  endtask

  task automatic testReset();
    enterReset();
    @(negedge clk);
    check("R1 halted in reset", {31'd0, halted}, 32'd0);
    check("R1 memWe in reset", {31'd0, memWe}, 32'd0);
  endtask

  task automatic testBasicSum();
    enterReset();
    mem[12'h300] = 16'h1940;
    mem[12'h301] = 16'h5941;
    mem[12'h302] = 16'h2941;
    mem[12'h303] = 16'h0000;
    mem[12'h940] = 16'h1234;
    mem[12'h941] = 16'h1111;
    runProgram();
    check("R5 sum stored", {16'd0, mem[12'h941]}, 32'h2345);
    check("R3 source kept", {16'd0, mem[12'h940]}, 32'h1234);
    check("R8 store clock", firstWe, 21);
    check("R4 single write", weCount, 1);
    check("R7 no stray write", {16'd0, mem[12'h942]}, 32'h0BAD);
  endtask

  task automatic testWrap();
    enterReset();
    mem[12'h300] = 16'h1940;
    mem[12'h301] = 16'h5941;
    mem[12'h302] = 16'h2941;
    mem[12'h303] = 16'h0000;
    mem[12'h940] = 16'hFFFF;
    mem[12'h941] = 16'h0003;
    runProgram();
    check("R5 wrap sum", {16'd0, mem[12'h941]}, 32'h0002);
  endtask

  task automatic testLoadReplaceAndHalt();
    logic [11:0] frozen;
    int lateWe;
    enterReset();
    mem[12'h300] = 16'h1A00;
    mem[12'h301] = 16'h1A02;
    mem[12'h302] = 16'h2A01;
    mem[12'h303] = 16'hF123;
    mem[12'h304] = 16'h2124;
    mem[12'hA00] = 16'h7777;
    mem[12'hA02] = 16'h0042;
    runProgram();
    check("R3 load replaces", {16'd0, mem[12'hA01]}, 32'h0042);
    check("R7 halt addr ignored", {16'd0, mem[12'h123]}, 32'h0BAD);
    frozen = memAddr;
    lateWe = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (memWe) lateWe++;
      if (memAddr !== frozen) lateWe++;
    end
    check("R7 frozen after halt", lateWe, 0);
    check("R7 halt sticky", {31'd0, halted}, 32'd1);
    check("R7 next word not run", {16'd0, mem[12'h124]}, 32'h0BAD);
  endtask

  task automatic testChain();
    enterReset();
    mem[12'h300] = 16'h1FFD;
    mem[12'h301] = 16'h5FFE;
    mem[12'h302] = 16'h5FFF;
    mem[12'h303] = 16'h5FFF;
    mem[12'h304] = 16'h2FFC;
    mem[12'h305] = 16'h3000;
    mem[12'hFFD] = 16'h0100;
    mem[12'hFFE] = 16'h0020;
    mem[12'hFFF] = 16'h0003;
    runProgram();
    check("R6 R2 chained sum", {16'd0, mem[12'hFFC]}, 32'h0126);
    check("R8 store clock in chain", firstWe, 8*4 + 5);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testBasicSum();
    testWrap();
    testLoadReplaceAndHalt();
    testChain();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule